// File: doc/BRIEF.md
# Multi-Ring Transmit Descriptor Engine

This block walks up to three transmit buffer-descriptor rings held in a word-wide synchronous memory. It gathers the buffers those rings point at into outgoing frames. Each ring has a start address and a kick flag. When a ring is kicked while the controller is enabled, the engine reads descriptors from that ring's saved pointer. It streams each ready buffer out as bytes and writes the descriptor back with its ready bit cleared. It then moves the ring pointer forward, or back to the ring start when the descriptor carries the wrap flag. A frame can span several descriptors. It closes on a descriptor marked last, and the frame length given with the final byte is the sum of the buffer lengths in that frame.

Each descriptor is two 32-bit words at an 8-byte-aligned address. The first word holds ready in bit 31, wrap in bit 29, interrupt-request in bit 28, last in bit 27 and the byte length in bits 15:0. The second word holds the buffer byte address, which is taken as word aligned. Buffer bytes are sent least significant byte of each word first. The memory returns read data one cycle after a read strobe.

The sequencer is a single state machine with eight states:
- IDLE: waits for a pending kick.
- HDR_RQ: issues the read of the first descriptor word.
- HDR: tests the ready bit. Going to PTR fetches the address word; going to DONE ends the pass.
- PTR: latches the buffer address and the length.
- LOAD: captures a buffer word.
- EMIT: sends one byte per cycle, returning to LOAD at each word boundary.
- WB: writes back the descriptor and advances the pointer.
- DONE: clears that ring's kick and goes back to IDLE.

Dropping the enable sends every state straight to IDLE.

Top module: `txring_engine`

## Requirements
- R1: Parameter NRINGS (default 1) sets how many rings are live. A start-address write or kick aimed at a ring index of NRINGS or above is ignored, and its kick flag stays 0.
- R2: A kick sets the ring's kick flag only while ctrl_en is 1. The flag reads 1 from the cycle after the kick until that ring's pass ends, and reads 0 afterwards.
- R3: A start-address write forces bits 2:0 to zero and also loads that ring's current pointer.
- R4: While ctrl_en is 0, all kick flags read 0 and every current pointer is reloaded from its start address.
- R5: Each consumed descriptor is written back to its own address with bit 31 (ready) cleared and every other bit unchanged. Reads and writes are never strobed together.
- R6: After write-back, the pointer returns to the ring start if bit 29 (wrap) was set, and otherwise advances by 8.
- R7: Buffer bytes are streamed in address order. out_last marks the final byte of a descriptor with bit 27 (last) set, and frame_len then equals the sum of the lengths of that frame's descriptors.
- R8: A descriptor with bit 28 (interrupt) set pulses irq_buf of its ring at write-back. If it is also last, it pulses irq_frame of that ring too. Without bit 28, neither pulses.
- R9: One pass consumes at most MAX_DESC descriptors. Each ring keeps its pointer between passes, so the next kick resumes where the last pass stopped.
- R10: A pass stops at the first descriptor whose ready bit is 0, without writing it. busy is 1 from the cycle after a kick until the last pending pass ends.
- R11: Kicks that arrive during a pass are queued. Pending rings are served in the order ring 0, ring 1, ring 2.
- R12: Reset clears every start address, current pointer and kick flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable |
| cfg_we | input | 1 | Start-address write strobe |
| cfg_ring | input | 2 | Ring selected by the start-address write |
| cfg_addr | input | AW | Start-address value |
| kick | input | 3 | Per-ring kick pulses |
| kick_pend | output | 3 | Per-ring kick flags |
| busy | output | 1 | Engine active or kick pending |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| frame_len | output | 16 | Frame length, valid with out_last |
| irq_buf | output | 3 | Per-ring buffer-done pulses |
| irq_frame | output | 3 | Per-ring frame-done pulses |

## Verification
The bench builds frames that span two descriptors and checks that the length given with the final byte is their sum. A design that reported only the last buffer's length, or did not clear the sum between frames, fails this check. The bench also runs a ring with more ready descriptors than one pass may take: the extra descriptors must stay ready and be picked up by the next kick. It resumes after a wrap descriptor and after a disable, both of which must restart from the start address rather than the advanced pointer. It kicks two rings together and a third during a pass, so that a wrong priority or a lost queued kick shows up in the byte order. A separate single-ring instance shows that a kick to a missing ring neither raises a flag nor touches memory.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 16;
    localparam int NSLOT     = 3;
    localparam int F_READY   = 31;
    localparam int F_WRAP    = 29;
    localparam int F_IRQ     = 28;
    localparam int F_LAST    = 27;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR_RQ, S_HDR, S_PTR, S_LOAD, S_EMIT, S_WB, S_DONE
    } txr_state_t;
endpackage

// File: rtl/txr_ring_regs.sv
module txr_ring_regs #(
    parameter int AW     = 32,
    parameter int NRINGS = 1,
    parameter int NSLOT  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctrl_en,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_ring,
    input  logic [AW-1:0]              cfg_addr,
    input  logic [NSLOT-1:0]           kick,
    input  logic                       adv_we,
    input  logic                       adv_wrap,
    input  logic [1:0]                 adv_ring,
    input  logic                       done_clr,
    input  logic [1:0]                 done_ring,
    output logic [NSLOT-1:0][AW-1:0]   start_q,
    output logic [NSLOT-1:0][AW-1:0]   cur_q,
    output logic [NSLOT-1:0]           pend_q
);
    localparam logic [AW-1:0] DESC_BYTES = AW'(8);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(7);

    logic [NSLOT-1:0] live_mask;
    logic [NSLOT-1:0] kick_ok;
    logic [AW-1:0]    cfg_aligned;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) live_mask[i] = (i < NRINGS);
    end

    assign kick_ok     = kick & live_mask & {NSLOT{ctrl_en}};
    assign cfg_aligned = cfg_addr & ALIGN_MASK;

    for (genvar r = 0; r < NSLOT; r++) begin : g_slot
        if (r < NRINGS) begin : g_live
            logic [AW-1:0] start_r, cur_r;
            logic          pend_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    start_r <= '0;
                    cur_r   <= '0;
                    pend_r  <= 1'b0;
                end else begin
                    if (!ctrl_en) begin
                        pend_r <= 1'b0;
                        cur_r  <= start_r;
                    end else begin
                        if (kick_ok[r])
                            pend_r <= 1'b1;
                        else if (done_clr && done_ring == 2'(r))
                            pend_r <= 1'b0;
                        if (adv_we && adv_ring == 2'(r))
                            cur_r <= adv_wrap ? start_r : cur_r + DESC_BYTES;
                    end
                    if (cfg_we && cfg_ring == 2'(r)) begin
                        start_r <= cfg_aligned;
                        cur_r   <= cfg_aligned;
                    end
                end
            end
            assign start_q[r] = start_r;
            assign cur_q[r]   = cur_r;
            assign pend_q[r]  = pend_r;
        end else begin : g_dead
            assign start_q[r] = '0;
            assign cur_q[r]   = '0;
            assign pend_q[r]  = 1'b0;
        end
    end
endmodule

// File: rtl/txr_pick.sv
module txr_pick #(
    parameter int NSLOT = 3
) (
    input  logic [NSLOT-1:0] req,
    output logic             any,
    output logic [1:0]       idx
);
    always_comb begin
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (req[i]) idx = 2'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
    parameter int AW       = 32,
    parameter int NRINGS   = 1,
    parameter int MAX_DESC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_en,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_ring,
    input  logic [AW-1:0] cfg_addr,
    input  logic [2:0]    kick,
    output logic [2:0]    kick_pend,
    output logic          busy,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic [15:0]   frame_len,
    output logic [2:0]    irq_buf,
    output logic [2:0]    irq_frame
);
    import txr_pkg::*;

    localparam int CW = $clog2(MAX_DESC + 1);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    txr_state_t st_q, st_d;
    logic [1:0]               ring_q;
    logic [CW-1:0]            cnt_q;
    logic [WORD_W-1:0]        hdr_q;
    logic [AW-1:0]            baddr_q;
    logic [LEN_W-1:0]         left_q;
    logic [1:0]               bsel_q;
    logic [WORD_W-1:0]        wreg_q;
    logic [NSLOT-1:0][LEN_W-1:0] facc_q;

    logic [NSLOT-1:0][AW-1:0] start_q, cur_q;
    logic [NSLOT-1:0]         pend_q;
    logic                     pick_any;
    logic [1:0]               pick_idx;
    logic [AW-1:0]            cur_sel;
    logic [LEN_W-1:0]         hdr_len;
    logic                     adv_we, done_clr;

    txr_ring_regs #(.AW(AW), .NRINGS(NRINGS), .NSLOT(NSLOT)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .cfg_we(cfg_we), .cfg_ring(cfg_ring), .cfg_addr(cfg_addr),
        .kick(kick), .adv_we(adv_we), .adv_wrap(hdr_q[F_WRAP]), .adv_ring(ring_q),
        .done_clr(done_clr), .done_ring(ring_q),
        .start_q(start_q), .cur_q(cur_q), .pend_q(pend_q)
    );

    txr_pick #(.NSLOT(NSLOT)) u_pick (
        .req(pend_q), .any(pick_any), .idx(pick_idx)
    );

    assign cur_sel   = cur_q[ring_q];
    assign hdr_len   = hdr_q[LEN_W-1:0];
    assign adv_we    = (st_q == S_WB);
    assign done_clr  = (st_q == S_DONE);
    assign kick_pend = pend_q;
    assign busy      = (st_q != S_IDLE) || pick_any;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!ctrl_en) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE:   if (pick_any) st_d = S_HDR_RQ;
                S_HDR_RQ: st_d = S_HDR;
                S_HDR:    st_d = mem_rdata[F_READY] ? S_PTR : S_DONE;
                S_PTR:    st_d = (hdr_len == '0) ? S_WB : S_LOAD;
                S_LOAD:   st_d = S_EMIT;
                S_EMIT: begin
                    if (left_q == LEN_W'(1))  st_d = S_WB;
                    else if (bsel_q == 2'd3)  st_d = S_LOAD;
                end
                S_WB:     st_d = (cnt_q == CW'(MAX_DESC - 1)) ? S_DONE : S_HDR_RQ;
                S_DONE:   st_d = S_IDLE;
                default:  st_d = S_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q  <= '0;
            cnt_q   <= '0;
            hdr_q   <= '0;
            baddr_q <= '0;
            left_q  <= '0;
            bsel_q  <= '0;
            wreg_q  <= '0;
            facc_q  <= '0;
        end else if (!ctrl_en) begin
            facc_q  <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (pick_any) begin
                    ring_q <= pick_idx;
                    cnt_q  <= '0;
                end
                S_HDR:  hdr_q <= mem_rdata;
                S_PTR: begin
                    baddr_q <= {mem_rdata[AW-1:2], 2'b00};
                    left_q  <= hdr_len;
                    bsel_q  <= '0;
                    facc_q[ring_q] <= facc_q[ring_q] + hdr_len;
                end
                S_LOAD: wreg_q <= mem_rdata;
                S_EMIT: begin
                    left_q <= left_q - LEN_W'(1);
                    bsel_q <= bsel_q + 2'd1;
                    if (bsel_q == 2'd3) baddr_q <= baddr_q + WORD_BYTES;
                end
                S_WB: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (hdr_q[F_LAST]) facc_q[ring_q] <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        frame_len = '0;
        irq_buf   = '0;
        irq_frame = '0;
        unique case (st_q)
            S_HDR_RQ: begin
                mem_rd   = 1'b1;
                mem_addr = cur_sel;
            end
            S_HDR: if (ctrl_en && mem_rdata[F_READY]) begin
                mem_rd   = 1'b1;
                mem_addr = cur_sel + WORD_BYTES;
            end
            S_PTR: if (hdr_len != '0) begin
                mem_rd   = 1'b1;
                mem_addr = {mem_rdata[AW-1:2], 2'b00};
            end
            S_EMIT: begin
                out_valid = 1'b1;
                out_data  = wreg_q[{bsel_q, 3'b000} +: 8];
                out_last  = (left_q == LEN_W'(1)) && hdr_q[F_LAST];
                frame_len = facc_q[ring_q];
                if (bsel_q == 2'd3 && left_q != LEN_W'(1)) begin
                    mem_rd   = 1'b1;
                    mem_addr = baddr_q + WORD_BYTES;
                end
            end
            S_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = cur_sel;
                mem_wdata = hdr_q & ~(32'd1 << F_READY);
                irq_buf[ring_q]   = hdr_q[F_IRQ];
                irq_frame[ring_q] = hdr_q[F_IRQ] && hdr_q[F_LAST];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int NRINGS = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_en,
    input logic [2:0] kick,
    input logic [2:0] kick_pend,
    input logic       busy,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       out_valid,
    input logic       out_last,
    input logic [2:0] irq_buf,
    input logic [2:0] irq_frame
);
    assert_rw_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_buf));
    assert_frame_implies_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_frame & ~irq_buf) == 3'b000);
    assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    assert_disabled_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> kick_pend == 3'b000);
    assert_stream_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    assert_dead_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_pend >> NRINGS) == 3'b000);
    assert_kick_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && kick[0]) |=> kick_pend[0]);
    assert_no_output_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr || out_valid));
endmodule

bind txring_engine txr_checker #(.NRINGS(NRINGS)) u_txr_checker (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .kick(kick),
    .kick_pend(kick_pend), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .out_valid(out_valid), .out_last(out_last),
    .irq_buf(irq_buf), .irq_frame(irq_frame)
);

// File: tb/tb_txring_engine.sv
module tb_txring_engine;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, ctrl_en, cfg_we;
    logic [1:0]  cfg_ring;
    logic [31:0] cfg_addr;
    logic [2:0]  kick;
    logic [2:0]  kick_pend;
    logic        busy, mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        out_valid, out_last;
    logic [7:0]  out_data;
    logic [15:0] frame_len;
    logic [2:0]  irq_buf, irq_frame;

    logic [2:0]  kick1, kick_pend1;
    logic        busy1, mem_rd1, mem_wr1, out_valid1, out_last1;
    logic [31:0] mem_addr1, mem_wdata1;
    logic [7:0]  out_data1;
    logic [15:0] frame_len1;
    logic [2:0]  irq_buf1, irq_frame1;

    txring_engine #(.NRINGS(3), .MAX_DESC(4)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cfg_we(cfg_we),
        .cfg_ring(cfg_ring), .cfg_addr(cfg_addr), .kick(kick), .kick_pend(kick_pend),
        .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .frame_len(frame_len),
        .irq_buf(irq_buf), .irq_frame(irq_frame)
    );

    txring_engine dut_single (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cfg_we(cfg_we),
        .cfg_ring(cfg_ring), .cfg_addr(cfg_addr), .kick(kick1), .kick_pend(kick_pend1),
        .busy(busy1), .mem_rd(mem_rd1), .mem_wr(mem_wr1), .mem_addr(mem_addr1),
        .mem_wdata(mem_wdata1), .mem_rdata(32'd0), .out_valid(out_valid1),
        .out_data(out_data1), .out_last(out_last1), .frame_len(frame_len1),
        .irq_buf(irq_buf1), .irq_frame(irq_frame1)
    );

    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    int nvec = 0, nerr = 0;
    logic [7:0] q[$];
    int nlast, single_mem;
    logic [15:0] last_len;
    int ib[3], ifr[3];

    always @(negedge clk) begin
        if (out_valid) q.push_back(out_data);
        if (out_valid && out_last) begin nlast++; last_len = frame_len; end
        for (int i = 0; i < 3; i++) begin
            if (irq_buf[i]) ib[i]++;
            if (irq_frame[i]) ifr[i]++;
        end
        if (mem_rd1 || mem_wr1) single_mem++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdrw(input bit rdy, input bit wrap, input bit irq,
                                         input bit last, input int len);
        return (32'(rdy) << 31) | (32'(wrap) << 29) | (32'(irq) << 28) |
               (32'(last) << 27) | 32'(len[15:0]);
    endfunction

    task automatic put_desc(input int addr, input bit rdy, input bit wrap, input bit irq,
                            input bit last, input int len, input int buf_a);
        mem[addr >> 2]       = hdrw(rdy, wrap, irq, last, len);
        mem[(addr >> 2) + 1] = 32'(buf_a);
    endtask

    task automatic clr;
        q.delete();
        nlast = 0; last_len = '0;
        for (int i = 0; i < 3; i++) begin ib[i] = 0; ifr[i] = 0; end
    endtask

    task automatic do_kick(input logic [2:0] m);
        @(negedge clk); kick = m;
        @(negedge clk); kick = 3'b000;
    endtask

    task automatic set_start(input int r, input int a);
        @(negedge clk); cfg_we = 1'b1; cfg_ring = 2'(r); cfg_addr = 32'(a);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wait_idle;
        int n = 0;
        repeat (2) @(negedge clk);
        while (busy && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic chk_stream(input string tag, input int off, input int base, input int len);
        for (int i = 0; i < len; i++) begin
            if (off + i < q.size()) chk(tag, 32'(q[off + i]), 32'(8'(base + i) ^ 8'h5A));
            else chk(tag, 32'hDEAD, 32'(8'(base + i) ^ 8'h5A));
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ctrl_en = 1'b0; cfg_we = 1'b0; cfg_ring = '0; cfg_addr = '0;
        kick = '0; kick1 = '0; single_mem = 0;
        for (int w = 0; w < 256; w++) begin
            if (w >= 128)
                mem[w] = {8'(4*w+3) ^ 8'h5A, 8'(4*w+2) ^ 8'h5A, 8'(4*w+1) ^ 8'h5A, 8'(4*w) ^ 8'h5A};
            else
                mem[w] = '0;
        end
        clr();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 kick flags after reset", 32'(kick_pend), 0);
        chk("R12 busy after reset", 32'(busy), 0);
        chk("R12 no stream after reset", 32'(out_valid), 0);
        rst_n = 1'b1;
        set_start(0, 32'h000);
        set_start(1, 32'h105);  // R3: low bits forced, ring base 0x100
        set_start(2, 32'h180);
        @(negedge clk); ctrl_en = 1'b1;

        // R7 R8 R5: two-descriptor frame on ring 0
        put_desc(32'h000, 1, 0, 1, 0, 5, 32'h200);
        put_desc(32'h008, 1, 0, 1, 1, 3, 32'h210);
        clr();
        do_kick(3'b001);
        chk("R10 busy after kick", 32'(busy), 1);
        chk("R2 kick flag set", 32'(kick_pend[0]), 1);
        wait_idle();
        chk("R7 byte count", 32'(q.size()), 8);
        chk_stream("R7 bytes buffer A", 0, 32'h200, 5);
        chk_stream("R7 bytes buffer B", 5, 32'h210, 3);
        chk("R7 one last marker", 32'(nlast), 1);
        chk("R7 frame length sum", 32'(last_len), 8);
        chk("R8 buffer-done count", 32'(ib[0]), 2);
        chk("R8 frame-done count", 32'(ifr[0]), 1);
        chk("R5 writeback first", mem[0], hdrw(0, 0, 1, 0, 5));
        chk("R5 writeback second", mem[2], hdrw(0, 0, 1, 1, 3));
        chk("R10 stop descriptor untouched", mem[4], 0);
        chk("R2 kick flag cleared", 32'(kick_pend), 0);

        // R9 R6 R8: resume at saved pointer, wrap back, no interrupt flag
        put_desc(32'h010, 1, 1, 0, 1, 4, 32'h220);
        put_desc(32'h000, 1, 0, 0, 1, 2, 32'h230);
        clr();
        do_kick(3'b001);
        wait_idle();
        chk("R9 resume byte count", 32'(q.size()), 6);
        chk_stream("R9 resume from saved pointer", 0, 32'h220, 4);
        chk_stream("R6 wrap to ring start", 4, 32'h230, 2);
        chk("R7 frames closed", 32'(nlast), 2);
        chk("R7 frame length reset", 32'(last_len), 2);
        chk("R8 no irq without flag", 32'(ib[0] + ifr[0]), 0);

        // R9 R3: six ready descriptors on ring 1, pass limit 4
        for (int k = 0; k < 6; k++) put_desc(32'h100 + 8*k, 1, 0, 1, 1, 1, 32'h240 + 4*k);
        clr();
        do_kick(3'b010);
        wait_idle();
        chk("R9 limited pass bytes", 32'(q.size()), 4);
        chk_stream("R3 aligned start", 0, 32'h240, 1);
        chk("R8 ring1 buffer-done", 32'(ib[1]), 4);
        chk("R8 ring1 frame-done", 32'(ifr[1]), 4);
        chk("R8 ring0 quiet", 32'(ib[0]), 0);
        chk("R9 fifth still ready", mem[32'h120 >> 2] >> 31, 1);
        clr();
        do_kick(3'b010);
        wait_idle();
        chk("R9 second pass bytes", 32'(q.size()), 2);
        chk_stream("R9 second pass continues", 0, 32'h250, 1);
        chk_stream("R9 second pass continues", 1, 32'h254, 1);

        // R11: ring1+ring2 together, ring0 while busy
        put_desc(32'h180, 1, 0, 0, 1, 3, 32'h260);
        put_desc(32'h130, 1, 0, 0, 1, 2, 32'h270);
        put_desc(32'h008, 1, 0, 0, 1, 1, 32'h280);
        clr();
        do_kick(3'b110);
        chk("R2 both flags", 32'(kick_pend), 3'b110);
        do_kick(3'b001);
        wait_idle();
        chk("R11 byte count", 32'(q.size()), 6);
        chk_stream("R11 ring1 first", 0, 32'h270, 2);
        chk_stream("R11 ring0 second", 2, 32'h280, 1);
        chk_stream("R11 ring2 third", 3, 32'h260, 3);
        chk("R2 all flags clear", 32'(kick_pend), 0);

        // R4 R2: disable ignores kicks and reloads pointers
        @(negedge clk); ctrl_en = 1'b0;
        clr();
        do_kick(3'b001);
        chk("R2 kick ignored while disabled", 32'(kick_pend), 0);
        chk("R4 not busy while disabled", 32'(busy), 0);
        @(negedge clk); ctrl_en = 1'b1;
        put_desc(32'h000, 1, 0, 0, 1, 2, 32'h290);
        do_kick(3'b001);
        wait_idle();
        chk("R4 reload byte count", 32'(q.size()), 2);
        chk_stream("R4 pointer reloaded from start", 0, 32'h290, 2);

        // R1: single-ring instance rejects ring 1
        @(negedge clk); kick1 = 3'b110; cfg_we = 1'b1; cfg_ring = 2'd1; cfg_addr = 32'h40;
        @(negedge clk); kick1 = 3'b000; cfg_we = 1'b0;
        chk("R1 dead ring flags", 32'(kick_pend1), 0);
        chk("R1 dead ring not busy", 32'(busy1), 0);
        repeat (4) @(negedge clk);
        chk("R1 no memory access", 32'(single_mem), 0);
        @(negedge clk); kick1 = 3'b001;
        @(negedge clk); kick1 = 3'b000;
        chk("R1 ring0 still accepted", 32'(kick_pend1[0]), 1);
        repeat (8) @(negedge clk);
        chk("R10 stop at not-ready", 32'(busy1), 0);

        // R12: reset clears pointers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R12 flags in reset", 32'(kick_pend), 0);
        rst_n = 1'b1;
        put_desc(32'h000, 1, 0, 0, 1, 1, 32'h2A0);
        clr();
        do_kick(3'b010);
        wait_idle();
        chk("R12 ring1 pointer zero", 32'(q.size()), 1);
        chk_stream("R12 ring1 from address 0", 0, 32'h2A0, 1);

        finish_run();
    end
endmodule